// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This block produces a fixed-precision estimate of 1/sqrt(x) for an IEEE-754 double-precision operand, with every bit of the result defined. It is meant to sit beside a floating-point unit as the seed generator for an iterative refinement step. The estimate itself is not refined here.

An operand enters on a valid/ready stream together with the current sticky status bits. The block decodes the operand into one of these cases:
- zeros
- infinities
- NaNs
- negative values
- subnormals
- positive normals

Special cases take fixed results. Subnormals are first renormalised. For finite positive operands, the block halves and negates the exponent. It then interpolates the mantissa from a 32-segment base/slope table, selected by four leading mantissa bits and by exponent parity.

The result and the updated status bits leave together on a second valid/ready stream, through one register stage. Back-pressure rules:
- The input is accepted when the output register is empty, or when it is being drained in the same cycle.
- A result that has not been taken stays unchanged until the downstream side raises `out_ready`.

Top module: `rsqrt_est`

## Requirements
- R1: A zero operand of either sign (bits 62:0 all zero) yields infinity of the same sign (exponent 0x7FF, mantissa 0) and sets the zero-divide status bit (`st_out[1]`).
- R2: +infinity yields +0, status unchanged. -infinity yields the default quiet NaN 0x7FF8000000000000 and sets the invalid-root status bit (`st_out[0]`).
- R3: A NaN operand (exponent 0x7FF, mantissa nonzero) is returned with bit 51 forced to 1 and all other bits kept. A NaN with bit 63 set also sets `st_out[0]`.
- R4: A nonzero, non-NaN operand with bit 63 set yields 0x7FF8000000000000 and sets `st_out[0]`.
- R5: The summary bit `st_out[2]` is set when R1 or R4 sets a bit that was 0 in `st_in`. Otherwise `st_out` equals the `st_in` sampled with the operand. A positive nonzero operand never changes the status.
- R6: A positive normal operand with biased exponent E gives sign 0, exponent (0x3FF - ((E - 0x3FD) >>> 1)) mod 2048, and result bits 25:0 all zero.
- R7: For positive finite operands, result bits 51:26 equal base[k] - slope[k] * f. Here f is mantissa bits 47:37 and k is mantissa bits 51:48, plus 16 when bit 0 of the (normalised) exponent is 0. The table is `seg_base`/`seg_slope` in `rsqrt_pkg`.
- R8: A subnormal operand is normalised before R6/R7. The mantissa is shifted left until its leading one reaches the hidden position, the exponent is 1 minus the shift count, and the hidden bit is then dropped.
- R9: `in_ready` is high when the output register is empty or is being drained. A stalled result keeps `out_data` and `st_out` stable. Results leave in acceptance order, one per accepted operand.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand can be accepted |
| in_data | input | 64 | Double-precision operand |
| st_in | input | 3 | Current sticky status: [2] summary, [1] zero-divide, [0] invalid-root |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 64 | Estimate |
| st_out | output | 3 | Updated status, same bit layout as `st_in` |

## Verification
Every table segment is visited with both exponent parities. Operands use exponents near 1.0 and at both ends of the normal range, so wrong segment selection, a wrong parity sense and exponent rounding errors each give distinct mismatches.

Subnormals are tested with the leading one at the top, in the middle and at bit 0; these expose off-by-one shift counts. Signed zeros, infinities, quiet and signalling NaNs of both signs, and negative finite values are each applied with the prior status bits both set and clear, which tells a missing sticky update apart from a wrongly repeated summary update.

Random operands are sent under random output stalls, which checks ordering and the hold behaviour.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  localparam int DW     = 64;
  localparam int EW     = 11;
  localparam int MW     = 52;
  localparam int SEGB   = 4;                 // mantissa bits that pick a segment
  localparam int FRW    = 11;                // interpolation fraction width
  localparam int KEYW   = SEGB + FRW;        // mantissa bits the table needs
  localparam int NSEG   = 2 << SEGB;         // segments over both parities
  localparam int IXW    = $clog2(NSEG);
  localparam int BW     = 26;                // base / result field width
  localparam int SW     = 11;                // slope width
  localparam int PW     = SW + FRW;          // product width
  localparam int SHIFT  = MW - BW;           // where the field lands
  localparam int ESW    = EW + 2;            // signed working exponent
  localparam int LZW    = $clog2(MW + 1);
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [DW-1:0] QNAN = 64'h7FF8_0000_0000_0000;

  // status bit positions
  localparam int ST_INV = 0;
  localparam int ST_ZD  = 1;
  localparam int ST_SUM = 2;
  localparam int STW    = 3;

  typedef enum logic [2:0] {
    K_ZERO, K_INF, K_NAN, K_NEG, K_FINITE
  } op_kind_e;

  function automatic logic [BW-1:0] seg_base(input logic [IXW-1:0] k);
    case (k)
      5'd0:  return 26'h3ffa000;  5'd1:  return 26'h3c29000;
      5'd2:  return 26'h38aa000;  5'd3:  return 26'h3572000;
      5'd4:  return 26'h3279000;  5'd5:  return 26'h2fb7000;
      5'd6:  return 26'h2d26000;  5'd7:  return 26'h2ac0000;
      5'd8:  return 26'h2881000;  5'd9:  return 26'h2665000;
      5'd10: return 26'h2468000;  5'd11: return 26'h2287000;
      5'd12: return 26'h20c1000;  5'd13: return 26'h1f12000;
      5'd14: return 26'h1d79000;  5'd15: return 26'h1bf4000;
      5'd16: return 26'h1a7e800;  5'd17: return 26'h17cb800;
      5'd18: return 26'h1552800;  5'd19: return 26'h130c000;
      5'd20: return 26'h10f2000;  5'd21: return 26'h0eff000;
      5'd22: return 26'h0d2e000;  5'd23: return 26'h0b7c000;
      5'd24: return 26'h09e5000;  5'd25: return 26'h0867000;
      5'd26: return 26'h06ff000;  5'd27: return 26'h05ab800;
      5'd28: return 26'h046a000;  5'd29: return 26'h0339800;
      5'd30: return 26'h0218800;  default: return 26'h0105800;
    endcase
  endfunction

  function automatic logic [SW-1:0] seg_slope(input logic [IXW-1:0] k);
    case (k)
      5'd0:  return 11'h7a4;  5'd1:  return 11'h700;
      5'd2:  return 11'h670;  5'd3:  return 11'h5f2;
      5'd4:  return 11'h584;  5'd5:  return 11'h524;
      5'd6:  return 11'h4cc;  5'd7:  return 11'h47e;
      5'd8:  return 11'h43a;  5'd9:  return 11'h3fa;
      5'd10: return 11'h3c2;  5'd11: return 11'h38e;
      5'd12: return 11'h35e;  5'd13: return 11'h332;
      5'd14: return 11'h30a;  5'd15: return 11'h2e6;
      5'd16: return 11'h568;  5'd17: return 11'h4f3;
      5'd18: return 11'h48d;  5'd19: return 11'h435;
      5'd20: return 11'h3e7;  5'd21: return 11'h3a2;
      5'd22: return 11'h365;  5'd23: return 11'h32e;
      5'd24: return 11'h2fc;  5'd25: return 11'h2d0;
      5'd26: return 11'h2a8;  5'd27: return 11'h283;
      5'd28: return 11'h261;  5'd29: return 11'h243;
      5'd30: return 11'h226;  default: return 11'h20b;
    endcase
  endfunction

endpackage

// File: rtl/rsqrt_classify.sv
module rsqrt_classify
  import rsqrt_pkg::*;
(
  input  logic [DW-1:0]  op,
  output op_kind_e       kind,
  output logic [DW-1:0]  fixed_res,
  output logic           hit_zd,
  output logic           hit_inv
);
  logic          sgn;
  logic [EW-1:0] ex;
  logic [MW-1:0] mn;

  assign sgn = op[DW-1];
  assign ex  = op[DW-2:MW];
  assign mn  = op[MW-1:0];

  always_comb begin
    kind      = K_FINITE;
    fixed_res = '0;
    hit_zd    = 1'b0;
    hit_inv   = 1'b0;
    if (ex == '0 && mn == '0) begin
      kind      = K_ZERO;
      fixed_res = {sgn, EMAX, {MW{1'b0}}};
      hit_zd    = 1'b1;
    end else if (ex == EMAX && mn == '0) begin
      kind      = K_INF;
      fixed_res = sgn ? QNAN : '0;
      hit_inv   = sgn;
    end else if (ex == EMAX) begin
      kind      = K_NAN;
      fixed_res = op | (DW'(1) << (MW - 1));
      hit_inv   = sgn;
    end else if (sgn) begin
      kind      = K_NEG;
      fixed_res = QNAN;
      hit_inv   = 1'b1;
    end
  end
endmodule

// File: rtl/rsqrt_normalize.sv
module rsqrt_normalize
  import rsqrt_pkg::*;
(
  input  logic [EW-1:0]         ex_in,
  input  logic [MW-1:0]         mn_in,
  output logic signed [ESW-1:0] ex_out,
  output logic [KEYW-1:0]       key_out
);
  logic [LZW-1:0] lz;
  logic [MW-1:0]  shifted;
  logic           sub;

  assign sub = (ex_in == '0);

  // leading-zero count; the highest set bit wins
  always_comb begin
    lz = LZW'(MW);
    for (int i = 0; i < MW; i++) begin
      if (mn_in[i]) lz = LZW'(MW - 1 - i);
    end
  end

  // shifting one past the leading zeros drops the hidden one off the top
  assign shifted = mn_in << (lz + LZW'(1));

  assign ex_out  = sub ? -$signed({{(ESW-LZW){1'b0}}, lz})
                       : $signed({{(ESW-EW){1'b0}}, ex_in});
  assign key_out = sub ? shifted[MW-1 -: KEYW] : mn_in[MW-1 -: KEYW];
endmodule

// File: rtl/rsqrt_interp.sv
module rsqrt_interp
  import rsqrt_pkg::*;
(
  input  logic signed [ESW-1:0] ex_n,
  input  logic [KEYW-1:0]       key,
  output logic [EW-1:0]         res_ex,
  output logic [BW-1:0]         res_mn
);
  logic [IXW-1:0]         k;
  logic [FRW-1:0]         frac;
  logic [PW-1:0]          prod;
  logic signed [ESW-1:0]  diff;
  logic signed [ESW-1:0]  newex;

  // even biased exponent selects the upper half of the table
  assign k    = {~ex_n[0], key[KEYW-1 -: SEGB]};
  assign frac = key[FRW-1:0];
  assign prod = PW'(seg_slope(k)) * PW'(frac);
  assign res_mn = seg_base(k) - BW'(prod);

  assign diff   = ex_n - ESW'(signed'(13'sd1021));
  assign newex  = ESW'(signed'(13'sd1023)) - (diff >>> 1);
  assign res_ex = newex[EW-1:0];
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsqrt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [63:0]     in_data,
  input  logic [2:0]      st_in,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [63:0]     out_data,
  output logic [2:0]      st_out
);
  op_kind_e              kind;
  logic [DW-1:0]         fixed_res;
  logic                  hit_zd, hit_inv;
  logic signed [ESW-1:0] ex_n;
  logic [KEYW-1:0]       key;
  logic [EW-1:0]         res_ex;
  logic [BW-1:0]         res_mn;
  logic [DW-1:0]         nxt_data;
  logic [STW-1:0]        nxt_st;
  logic                  take;

  rsqrt_classify u_cls (
    .op(in_data), .kind(kind), .fixed_res(fixed_res),
    .hit_zd(hit_zd), .hit_inv(hit_inv)
  );

  rsqrt_normalize u_norm (
    .ex_in(in_data[DW-2:MW]), .mn_in(in_data[MW-1:0]),
    .ex_out(ex_n), .key_out(key)
  );

  rsqrt_interp u_int (
    .ex_n(ex_n), .key(key), .res_ex(res_ex), .res_mn(res_mn)
  );

  assign nxt_data = (kind == K_FINITE) ? {1'b0, res_ex, res_mn, {SHIFT{1'b0}}}
                                       : fixed_res;

  always_comb begin
    nxt_st = st_in;
    if (hit_zd) begin
      nxt_st[ST_ZD] = 1'b1;
      if (!st_in[ST_ZD]) nxt_st[ST_SUM] = 1'b1;
    end
    if (hit_inv) begin
      nxt_st[ST_INV] = 1'b1;
      if (!st_in[ST_INV]) nxt_st[ST_SUM] = 1'b1;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      st_out    <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= nxt_data;
      st_out    <= nxt_st;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_data,
  input logic [2:0]  st_in,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic [2:0]  st_out
);
  logic acc, is_zero, is_nan, is_pos_norm;
  assign acc         = in_valid && in_ready;
  assign is_zero     = (in_data[62:0] == '0);
  assign is_nan      = (in_data[62:52] == 11'h7FF) && (in_data[51:0] != '0);
  assign is_pos_norm = !in_data[63] && in_data[62:52] != 11'h0 && in_data[62:52] != 11'h7FF;

  AST_ZERO_INF: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_zero |=> out_data == {$past(in_data[63]), 11'h7FF, 52'h0} && st_out[1]); // R1

  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_nan |=> out_data[51] && out_data[63:52] == $past(in_data[63:52])); // R3

  AST_NEG_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_data[63] && !is_zero && !is_nan |=> out_data == 64'h7FF8_0000_0000_0000 && st_out[0]); // R4

  AST_POS_KEEP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_data[63] && !is_zero |=> st_out == $past(st_in)); // R5

  AST_ZD_NO_RESUM: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_zero && st_in[1] |=> st_out[2] == $past(st_in[2])); // R5

  AST_NORM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_pos_norm |=> !out_data[63] && out_data[25:0] == '0); // R6

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(st_out)); // R9
endmodule

bind rsqrt_est rsqrt_est_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .st_in(st_in), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .st_out(st_out)
);

// File: tb/rsqrt_est_test.sv
`timescale 1ns/1ps
module rsqrt_est_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [2:0]  st_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic [2:0]  st_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit stall_mode = 1'b0;

  logic [63:0] exp_q[$];
  logic [2:0]  est_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  rsqrt_est uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .st_in(st_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .st_out(st_out)
  );

  int unsigned bases[32] = '{
    'h3ffa000, 'h3c29000, 'h38aa000, 'h3572000, 'h3279000, 'h2fb7000, 'h2d26000, 'h2ac0000,
    'h2881000, 'h2665000, 'h2468000, 'h2287000, 'h20c1000, 'h1f12000, 'h1d79000, 'h1bf4000,
    'h1a7e800, 'h17cb800, 'h1552800, 'h130c000, 'h10f2000, 'h0eff000, 'h0d2e000, 'h0b7c000,
    'h09e5000, 'h0867000, 'h06ff000, 'h05ab800, 'h046a000, 'h0339800, 'h0218800, 'h0105800};
  int unsigned slopes[32] = '{
    'h7a4, 'h700, 'h670, 'h5f2, 'h584, 'h524, 'h4cc, 'h47e,
    'h43a, 'h3fa, 'h3c2, 'h38e, 'h35e, 'h332, 'h30a, 'h2e6,
    'h568, 'h4f3, 'h48d, 'h435, 'h3e7, 'h3a2, 'h365, 'h32e,
    'h2fc, 'h2d0, 'h2a8, 'h283, 'h261, 'h243, 'h226, 'h20b};

  task automatic check(input string req, input logic [66:0] act, input logic [66:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // reference model: integer arithmetic on the field values
  task automatic model(input logic [63:0] x, input logic [2:0] s,
                       output logic [63:0] r, output logic [2:0] so, output string tag);
    logic sg;
    int   e;
    longint unsigned m, t, mant, k, f;
    longint signed d;
    sg = x[63]; e = int'(x[62:52]); m = longint'(x[51:0]);
    so = s; r = '0;
    if (e == 0 && m == 0) begin
      r = {sg, 11'h7FF, 52'h0}; tag = "R1";
      so[1] = 1'b1; if (!s[1]) so[2] = 1'b1;
    end else if (e == 2047) begin
      if (m == 0) begin r = sg ? 64'h7FF8000000000000 : 64'h0; tag = "R2"; end
      else begin r = x | (64'h1 << 51); tag = "R3"; end
      if (sg) begin so[0] = 1'b1; if (!s[0]) so[2] = 1'b1; end
    end else if (sg) begin
      r = 64'h7FF8000000000000; tag = "R4";
      so[0] = 1'b1; if (!s[0]) so[2] = 1'b1;
    end else begin
      tag = "R7";
      if (e == 0) begin
        tag = "R8";
        e = 0;
        do begin e = e - 1; m = m << 1; end while (m[52] == 1'b0);
        e = e + 1;
        m = m & ((64'h1 << 52) - 1);
      end
      d = longint'(e - 1022) <<< 52;
      t = ((longint'(1023) << 52) - longint'(d / 2)) & (longint'(2047) << 52);
      k = (m >> 48) + ((e % 2 == 0) ? 16 : 0);
      f = (m >> 37) & 'h7FF;
      mant = longint'(bases[k]) - longint'(slopes[k]) * f;
      r = t | (mant << 26);
    end
  endtask

  task automatic send(input logic [63:0] x, input logic [2:0] s);
    logic [63:0] r; logic [2:0] so; string tag;
    model(x, s, r, so, tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = x; st_in = s;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    exp_q.push_back(r); est_q.push_back(so); tag_q.push_back(tag);
    @(posedge clk);
    #0.5 in_valid = 1'b0;
  endtask

  // monitor: choose ready, then compare every transfer and every stall
  logic        was_stall = 1'b0;
  logic [66:0] held = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (was_stall) check("R9 hold", {out_valid, st_out, out_data}, {1'b1, held[66:0]} [66:0]);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check("R9 extra", {3'b0, out_data}, 67'h0 - 1);
        else begin
          string tg;
          tg = tag_q.pop_front();
          check({tg, " data"}, {3'b0, out_data}, {3'b0, exp_q.pop_front()});
          check("R5 status", {64'h0, st_out}, {64'h0, est_q.pop_front()});
        end
      end
      was_stall = out_valid && !out_ready;
      held = {st_out, out_data};
    end
  end

  initial begin
    #100000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid", {66'h0, out_valid}, 67'h0);
    rst_n = 1'b1;
    #1 check("R10 in_ready", {66'h0, in_ready}, 67'h1);
    // R1 zeros with status clear and set
    send(64'h0000000000000000, 3'b000);
    send(64'h8000000000000000, 3'b010);
    send(64'h8000000000000000, 3'b001);
    // R2 infinities
    send(64'h7FF0000000000000, 3'b101);
    send(64'hFFF0000000000000, 3'b000);
    send(64'hFFF0000000000000, 3'b001);
    // R3 NaNs: quiet, signalling, negative
    send(64'h7FF8000000001234, 3'b000);
    send(64'h7FF0000000000001, 3'b110);
    send(64'hFFF4000000000000, 3'b000);
    // R4 negative finite
    send(64'hBFF0000000000000, 3'b010);
    send(64'h800000000000000F, 3'b111);
    // R8 subnormals
    send(64'h0008000000000000, 3'b000);
    send(64'h0000000000000001, 3'b000);
    send(64'h0000012345678ABC, 3'b011);
    send(64'h000FFFFFFFFFFFFF, 3'b000);
    // R6 R7 every segment, both parities, range ends
    for (int k = 0; k < 16; k++) begin
      logic [47:0] lo;
      lo = {$urandom, $urandom_range(0, 65535)};
      send({1'b0, 11'd1023, k[3:0], lo}, 3'b000);
      send({1'b0, 11'd1024, k[3:0], lo}, 3'b000);
    end
    send({1'b0, 11'd1, 52'hFFFFFFFFFFFFF}, 3'b000);
    send({1'b0, 11'd2, 52'h0}, 3'b000);
    send({1'b0, 11'd2046, 52'hFFFFFFFFFFFFF}, 3'b000);
    send({1'b0, 11'd2045, 52'h8000000000000}, 3'b000);
    // R9 random traffic under back-pressure
    stall_mode = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (n % 7 == 0) v[62:52] = 11'h0;
      if (n % 11 == 0) v[62:52] = 11'h7FF;
      send(v, 3'($urandom_range(0, 7)));
    end
    stall_mode = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 drained", {63'h0, 4'(exp_q.size())}, 67'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule